// File: doc/BRIEF.md
# Timer Channel Output Conditioning Chain

This block takes the event pulses of one timer channel and produces two pin levels: a main output and its complementary partner. The counter, the compare/capture logic and the deadband generator sit outside. Their zero, load, direction, compare-hit and capture-hit pulses, plus the two deadband-shaped waveforms, arrive here as inputs. Inside, a registered waveform bit is set, cleared or toggled by those events. A source selector then decides what reaches the pins, a software force can replace each output on its own, a fault or debugger-halt condition can drive both outputs to programmable safe levels, and a final polarity inversion and an output-disable gate close the chain.

The chain is a fixed priority ladder. Each later stage may overrule the stages before it, and one set of controls governs both outputs in parallel. While the counter enable is low, the pins show a programmable idle level, and the waveform register is preset to that level so that generation resumes from it.

Top module: `chan_out_cond`

## Requirements
- R1: While `rst` is high at a clock edge, the waveform register clears to 0 and the captured fault and halt flags clear. With the generated waveform selected, no force and no override, this gives `pin_main`=0 and `pin_comp`=1.
- R2: While `cnt_en`=0 and `out_dis`=0, `pin_main` equals `idle_lvl` and `pin_comp` equals its inverse. Each clock edge with `cnt_en`=0 loads `idle_lvl` into the waveform register.
- R3: Each 2-bit action code is applied to the waveform register at the clock edge: 00 leaves it unchanged, 01 sets it to 1, 10 clears it to 0, 11 inverts it. The complementary generated value is the inverse of the register.
- R4: When several events occur in the same cycle, only the highest-ranked one decides the action, even if its code is 00. The ranking is zero event first, then load event, then compare-while-up, then compare-while-down.
- R5: A compare hit uses `act_cmp_up` when `cnt_up`=1 and `act_cmp_dn` when `cnt_up`=0.
- R6: `src_sel` selects the main source: 0 generated waveform, 1 deadband waveform, 2 zero event, 3 load event, 4 compare hit, 5 capture hit, 6 fault input level, 7 external input. For source 1 the complementary output takes `dead_comp`. For every other source it takes the inverse of the main source.
- R7: `frc_main` and `frc_comp` act independently on their own output: 00 no force, 01 low, 10 high, 11 the inverse of the selected value.
- R8: `fault_lvl` and `dbg_halt` are captured at the clock edge. From the next cycle, a captured fault with `flt_ovr_en`=1, or a captured halt with `dbg_ovr_en`=1, drives the outputs to `safe_main`/`safe_comp`.
- R9: With `flt_ovr_en`=1, a high `fault_async` drives both outputs to their safe levels in the same cycle, with no clock edge needed.
- R10: `inv_en`=1 inverts both outputs after the override stage.
- R11: `out_dis`=1 holds both pins low, regardless of every other input, including the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter running |
| evt_zero | input | 1 | Counter zero event pulse |
| evt_load | input | 1 | Counter load event pulse |
| cnt_up | input | 1 | Counting direction, 1 = up |
| cmp_hit | input | 1 | Compare-match event pulse |
| cap_hit | input | 1 | Capture event pulse |
| dead_main | input | 1 | Deadband-shaped main waveform |
| dead_comp | input | 1 | Deadband-shaped complementary waveform |
| sig_in | input | 1 | External signal input |
| fault_lvl | input | 1 | Synchronous fault condition |
| fault_async | input | 1 | Asynchronous fault condition |
| dbg_halt | input | 1 | Debugger halted |
| act_zero | input | 2 | Action on zero event |
| act_load | input | 2 | Action on load event |
| act_cmp_up | input | 2 | Action on compare while counting up |
| act_cmp_dn | input | 2 | Action on compare while counting down |
| src_sel | input | 3 | Output source select |
| frc_main | input | 2 | Software force for main output |
| frc_comp | input | 2 | Software force for complementary output |
| flt_ovr_en | input | 1 | Enable fault override |
| dbg_ovr_en | input | 1 | Enable debug-halt override |
| safe_main | input | 1 | Safe level for main output |
| safe_comp | input | 1 | Safe level for complementary output |
| inv_en | input | 1 | Final polarity inversion |
| out_dis | input | 1 | Output disable, holds pins low |
| idle_lvl | input | 1 | Pin level while counter is off |
| pin_main | output | 1 | Main output pin |
| pin_comp | output | 1 | Complementary output pin |

## Verification
The hardest situations to reach are the registered corners. One is a captured fault or halt that takes effect one cycle after its input rose, while the asynchronous fault acts at once. The other is a waveform register that carries history across many random event collisions. Directed sequences raise the synchronous fault and check the pin both before and after the capturing edge. They also fire several events in one cycle with the higher-ranked action set to no-op. Random stimulus keeps events sparse and overrides rare, so the waveform register builds a long history, and a bench model tracks that history edge by edge.

// File: rtl/chan_out_pkg.sv
package chan_out_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        FRC_OFF  = 2'b00,
        FRC_LOW  = 2'b01,
        FRC_HIGH = 2'b10,
        FRC_INV  = 2'b11
    } frc_e;

    typedef enum logic [2:0] {
        SRC_WAVE  = 3'd0,
        SRC_DEAD  = 3'd1,
        SRC_ZERO  = 3'd2,
        SRC_LOAD  = 3'd3,
        SRC_CMP   = 3'd4,
        SRC_CAP   = 3'd5,
        SRC_FAULT = 3'd6,
        SRC_EXT   = 3'd7
    } src_e;

    localparam int LANES    = 2;
    localparam int LANE_MAIN = 0;
    localparam int LANE_COMP = 1;

    typedef logic [LANES-1:0] lane_vec_t;

    function automatic logic apply_act(act_e a, logic cur);
        case (a)
            ACT_SET: return 1'b1;
            ACT_CLR: return 1'b0;
            ACT_TGL: return ~cur;
            default: return cur;
        endcase
    endfunction

    function automatic logic apply_frc(frc_e f, logic cur);
        case (f)
            FRC_LOW:  return 1'b0;
            FRC_HIGH: return 1'b1;
            FRC_INV:  return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/chan_wave_gen.sv
module chan_wave_gen
    import chan_out_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_en,
    input  logic       evt_zero,
    input  logic       evt_load,
    input  logic       cnt_up,
    input  logic       cmp_hit,
    input  act_e       act_zero,
    input  act_e       act_load,
    input  act_e       act_cmp_up,
    input  act_e       act_cmp_dn,
    input  logic       idle_lvl,
    output logic       wave
);

    act_e win_act;

    // ranked event arbitration: first present event owns the action
    always_comb begin
        if (evt_zero)               win_act = act_zero;
        else if (evt_load)          win_act = act_load;
        else if (cmp_hit && cnt_up) win_act = act_cmp_up;
        else if (cmp_hit)           win_act = act_cmp_dn;
        else                        win_act = ACT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst)          wave <= 1'b0;
        else if (!cnt_en) wave <= idle_lvl;
        else              wave <= apply_act(win_act, wave);
    end

    p_idle_preset_r2: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> wave == $past(idle_lvl));

    p_zero_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && evt_zero && act_zero == ACT_NONE) |=> $stable(wave));

    p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && evt_zero && act_zero == ACT_TGL) |=> wave != $past(wave));

endmodule

// File: rtl/chan_src_stage.sv
module chan_src_stage
    import chan_out_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wave,
    input  logic       dead_main,
    input  logic       dead_comp,
    input  logic       evt_zero,
    input  logic       evt_load,
    input  logic       cmp_hit,
    input  logic       cap_hit,
    input  logic       fault_lvl,
    input  logic       sig_in,
    input  src_e       src_sel,
    input  frc_e       frc_main,
    input  frc_e       frc_comp,
    output lane_vec_t  forced
);

    lane_vec_t raw;
    frc_e      frc_lane [LANES];
    logic      sel_main;

    always_comb begin
        case (src_sel)
            SRC_WAVE:  sel_main = wave;
            SRC_DEAD:  sel_main = dead_main;
            SRC_ZERO:  sel_main = evt_zero;
            SRC_LOAD:  sel_main = evt_load;
            SRC_CMP:   sel_main = cmp_hit;
            SRC_CAP:   sel_main = cap_hit;
            SRC_FAULT: sel_main = fault_lvl;
            default:   sel_main = sig_in;
        endcase
        raw[LANE_MAIN] = sel_main;
        raw[LANE_COMP] = (src_sel == SRC_DEAD) ? dead_comp : ~sel_main;
    end

    assign frc_lane[LANE_MAIN] = frc_main;
    assign frc_lane[LANE_COMP] = frc_comp;

    for (genvar g = 0; g < LANES; g++) begin : g_force
        assign forced[g] = apply_frc(frc_lane[g], raw[g]);
    end

    p_force_high_r7: assert property (@(posedge clk) disable iff (rst)
        frc_main == FRC_HIGH |-> forced[LANE_MAIN]);

    p_force_low_comp_r7: assert property (@(posedge clk) disable iff (rst)
        frc_comp == FRC_LOW |-> !forced[LANE_COMP]);

endmodule

// File: rtl/chan_override.sv
module chan_override
    import chan_out_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lane_vec_t  din,
    input  logic       fault_lvl,
    input  logic       fault_async,
    input  logic       dbg_halt,
    input  logic       flt_ovr_en,
    input  logic       dbg_ovr_en,
    input  lane_vec_t  safe_lvl,
    output lane_vec_t  dout
);

    logic flt_q;
    logic halt_q;
    logic take_safe;

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_q  <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            flt_q  <= fault_lvl;
            halt_q <= dbg_halt;
        end
    end

    assign take_safe = (flt_ovr_en && (flt_q || fault_async)) || (dbg_ovr_en && halt_q);

    for (genvar g = 0; g < LANES; g++) begin : g_ovr
        assign dout[g] = take_safe ? safe_lvl[g] : din[g];
    end

    p_async_fault_r9: assert property (@(posedge clk) disable iff (rst)
        (flt_ovr_en && fault_async) |-> dout == safe_lvl);

    p_halt_safe_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dbg_halt) && dbg_ovr_en) |-> dout == safe_lvl);

    p_no_override_r8: assert property (@(posedge clk) disable iff (rst)
        (!flt_ovr_en && !dbg_ovr_en) |-> dout == din);

endmodule

// File: rtl/chan_out_cond.sv
module chan_out_cond
    import chan_out_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_en,
    input  logic       evt_zero,
    input  logic       evt_load,
    input  logic       cnt_up,
    input  logic       cmp_hit,
    input  logic       cap_hit,
    input  logic       dead_main,
    input  logic       dead_comp,
    input  logic       sig_in,
    input  logic       fault_lvl,
    input  logic       fault_async,
    input  logic       dbg_halt,
    input  logic [1:0] act_zero,
    input  logic [1:0] act_load,
    input  logic [1:0] act_cmp_up,
    input  logic [1:0] act_cmp_dn,
    input  logic [2:0] src_sel,
    input  logic [1:0] frc_main,
    input  logic [1:0] frc_comp,
    input  logic       flt_ovr_en,
    input  logic       dbg_ovr_en,
    input  logic       safe_main,
    input  logic       safe_comp,
    input  logic       inv_en,
    input  logic       out_dis,
    input  logic       idle_lvl,
    output logic       pin_main,
    output logic       pin_comp
);

    logic      wave;
    lane_vec_t forced;
    lane_vec_t guarded;
    lane_vec_t safe_vec;
    lane_vec_t idle_vec;
    lane_vec_t pins;

    chan_wave_gen u_wave (
        .clk        (clk),
        .rst        (rst),
        .cnt_en     (cnt_en),
        .evt_zero   (evt_zero),
        .evt_load   (evt_load),
        .cnt_up     (cnt_up),
        .cmp_hit    (cmp_hit),
        .act_zero   (act_e'(act_zero)),
        .act_load   (act_e'(act_load)),
        .act_cmp_up (act_e'(act_cmp_up)),
        .act_cmp_dn (act_e'(act_cmp_dn)),
        .idle_lvl   (idle_lvl),
        .wave       (wave)
    );

    chan_src_stage u_src (
        .clk        (clk),
        .rst        (rst),
        .wave       (wave),
        .dead_main  (dead_main),
        .dead_comp  (dead_comp),
        .evt_zero   (evt_zero),
        .evt_load   (evt_load),
        .cmp_hit    (cmp_hit),
        .cap_hit    (cap_hit),
        .fault_lvl  (fault_lvl),
        .sig_in     (sig_in),
        .src_sel    (src_e'(src_sel)),
        .frc_main   (frc_e'(frc_main)),
        .frc_comp   (frc_e'(frc_comp)),
        .forced     (forced)
    );

    assign safe_vec[LANE_MAIN] = safe_main;
    assign safe_vec[LANE_COMP] = safe_comp;
    assign idle_vec[LANE_MAIN] = idle_lvl;
    assign idle_vec[LANE_COMP] = ~idle_lvl;

    chan_override u_ovr (
        .clk         (clk),
        .rst         (rst),
        .din         (forced),
        .fault_lvl   (fault_lvl),
        .fault_async (fault_async),
        .dbg_halt    (dbg_halt),
        .flt_ovr_en  (flt_ovr_en),
        .dbg_ovr_en  (dbg_ovr_en),
        .safe_lvl    (safe_vec),
        .dout        (guarded)
    );

    // final ladder: disable, then idle, then polarity
    for (genvar g = 0; g < LANES; g++) begin : g_pin
        always_comb begin
            if (out_dis)      pins[g] = 1'b0;
            else if (!cnt_en) pins[g] = idle_vec[g];
            else              pins[g] = guarded[g] ^ inv_en;
        end
    end

    assign pin_main = pins[LANE_MAIN];
    assign pin_comp = pins[LANE_COMP];

    p_disable_low_r11: assert property (@(posedge clk) disable iff (rst)
        out_dis |-> (!pin_main && !pin_comp));

    p_idle_level_r2: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !out_dis) |-> (pin_main == idle_lvl && pin_comp != idle_lvl));

    p_invert_r10: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !out_dis && inv_en) |-> pin_main != guarded[LANE_MAIN]);

endmodule

// File: tb/chan_out_cond_tb.sv
module chan_out_cond_tb;

    logic clk = 1'b0;
    logic rst;
    logic cnt_en, evt_zero, evt_load, cnt_up, cmp_hit, cap_hit;
    logic dead_main, dead_comp, sig_in, fault_lvl, fault_async, dbg_halt;
    logic [1:0] act_zero, act_load, act_cmp_up, act_cmp_dn;
    logic [2:0] src_sel;
    logic [1:0] frc_main, frc_comp;
    logic flt_ovr_en, dbg_ovr_en, safe_main, safe_comp, inv_en, out_dis, idle_lvl;
    logic pin_main, pin_comp;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model state
    logic m_wave, m_flt, m_halt;

    always #2 clk = ~clk;  // 250 MHz

    chan_out_cond u_dut (.*);

    function automatic logic f_act(logic [1:0] a, logic w);
        case (a)
            2'b01: return 1'b1;
            2'b10: return 1'b0;
            2'b11: return ~w;
            default: return w;
        endcase
    endfunction

    function automatic logic f_frc(logic [1:0] f, logic v);
        case (f)
            2'b01: return 1'b0;
            2'b10: return 1'b1;
            2'b11: return ~v;
            default: return v;
        endcase
    endfunction

    function automatic logic [1:0] f_expect();
        logic sm, sc, om, oc;
        case (src_sel)
            3'd0: sm = m_wave;
            3'd1: sm = dead_main;
            3'd2: sm = evt_zero;
            3'd3: sm = evt_load;
            3'd4: sm = cmp_hit;
            3'd5: sm = cap_hit;
            3'd6: sm = fault_lvl;
            default: sm = sig_in;
        endcase
        sc = (src_sel == 3'd1) ? dead_comp : ~sm;
        om = f_frc(frc_main, sm);
        oc = f_frc(frc_comp, sc);
        if ((flt_ovr_en && (fault_async || m_flt)) || (dbg_ovr_en && m_halt)) begin
            om = safe_main;
            oc = safe_comp;
        end
        om = om ^ inv_en;
        oc = oc ^ inv_en;
        if (!cnt_en) begin
            om = idle_lvl;
            oc = ~idle_lvl;
        end
        if (out_dis) begin
            om = 1'b0;
            oc = 1'b0;
        end
        return {om, oc};
    endfunction

    function automatic string f_tag();
        if (out_dis) return "R11";
        if (!cnt_en) return "R2";
        if (flt_ovr_en && fault_async) return "R9";
        if ((flt_ovr_en && m_flt) || (dbg_ovr_en && m_halt)) return "R8";
        if (frc_main != 0 || frc_comp != 0) return "R7";
        if (inv_en) return "R10";
        if (src_sel != 0) return "R6";
        return "R3";
    endfunction

    task automatic check(string tag);
        logic [1:0] e;
        e = f_expect();
        n_chk++;
        if ({pin_main, pin_comp} !== e) begin
            n_fail++;
            $display("FAIL %s: pins main/comp = %b%b expected %b%b", tag, pin_main, pin_comp, e[1], e[0]);
        end
    endtask

    // advance one edge, updating the model from inputs held across it
    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_wave = 1'b0; m_flt = 1'b0; m_halt = 1'b0;
        end else begin
            logic [1:0] a;
            m_flt = fault_lvl;
            m_halt = dbg_halt;
            if (evt_zero)               a = act_zero;
            else if (evt_load)          a = act_load;
            else if (cmp_hit && cnt_up) a = act_cmp_up;
            else if (cmp_hit)           a = act_cmp_dn;
            else                        a = 2'b00;
            m_wave = cnt_en ? f_act(a, m_wave) : idle_lvl;
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        cnt_en = 1; evt_zero = 0; evt_load = 0; cnt_up = 1; cmp_hit = 0; cap_hit = 0;
        dead_main = 0; dead_comp = 0; sig_in = 0; fault_lvl = 0; fault_async = 0; dbg_halt = 0;
        act_zero = 0; act_load = 0; act_cmp_up = 0; act_cmp_dn = 0; src_sel = 0;
        frc_main = 0; frc_comp = 0; flt_ovr_en = 0; dbg_ovr_en = 0;
        safe_main = 0; safe_comp = 0; inv_en = 0; out_dis = 0; idle_lvl = 0;
    endtask

    task automatic set_wave(logic v);
        evt_zero = 1; act_zero = v ? 2'b01 : 2'b10;
        tick();
        evt_zero = 0; act_zero = 0;
    endtask

    task automatic rnd_step();
        cnt_en      = ($urandom_range(0, 9) != 0);
        evt_zero    = ($urandom_range(0, 5) == 0);
        evt_load    = ($urandom_range(0, 5) == 0);
        cnt_up      = 1'($urandom);
        cmp_hit     = ($urandom_range(0, 3) == 0);
        cap_hit     = 1'($urandom);
        dead_main   = 1'($urandom);
        dead_comp   = 1'($urandom);
        sig_in      = 1'($urandom);
        fault_lvl   = ($urandom_range(0, 7) == 0);
        fault_async = ($urandom_range(0, 9) == 0);
        dbg_halt    = ($urandom_range(0, 7) == 0);
        act_zero    = 2'($urandom);
        act_load    = 2'($urandom);
        act_cmp_up  = 2'($urandom);
        act_cmp_dn  = 2'($urandom);
        src_sel     = ($urandom_range(0, 2) == 0) ? 3'($urandom) : 3'd0;
        frc_main    = ($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'd0;
        frc_comp    = ($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'd0;
        flt_ovr_en  = ($urandom_range(0, 3) == 0);
        dbg_ovr_en  = ($urandom_range(0, 3) == 0);
        safe_main   = 1'($urandom);
        safe_comp   = 1'($urandom);
        inv_en      = 1'($urandom);
        out_dis     = ($urandom_range(0, 15) == 0);
        idle_lvl    = 1'($urandom);
        #1;
        check(f_tag());
        tick();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        quiet();
        rst = 1;
        m_wave = 0; m_flt = 0; m_halt = 0;
        @(negedge clk);
        tick(); tick();
        check("R1 reset state");
        rst = 0;
        tick();

        // R2: idle level, then preset of the waveform register
        cnt_en = 0; idle_lvl = 1; #1; check("R2 idle high");
        tick(); idle_lvl = 0; #1; check("R2 idle low");
        cnt_en = 1; idle_lvl = 1; tick();
        cnt_en = 1; #1; check("R2 wave holds last idle value");

        // R3: each action code
        set_wave(0); #1; check("R3 clear");
        set_wave(1); #1; check("R3 set");
        evt_load = 1; act_load = 2'b11; tick(); evt_load = 0; #1; check("R3 toggle");
        evt_load = 1; act_load = 2'b00; tick(); evt_load = 0; #1; check("R3 none holds");

        // R4: zero outranks load even with no-op action
        set_wave(0);
        evt_zero = 1; act_zero = 2'b00; evt_load = 1; act_load = 2'b01;
        cmp_hit = 1; act_cmp_up = 2'b01; tick();
        evt_zero = 0; evt_load = 0; cmp_hit = 0; #1; check("R4 zero no-op wins");
        evt_load = 1; act_load = 2'b00; cmp_hit = 1; act_cmp_up = 2'b01; tick();
        evt_load = 0; cmp_hit = 0; #1; check("R4 load no-op beats compare");

        // R5: compare direction
        set_wave(0);
        cmp_hit = 1; cnt_up = 0; act_cmp_up = 2'b10; act_cmp_dn = 2'b01; tick();
        cmp_hit = 0; #1; check("R5 compare down uses down action");
        cmp_hit = 1; cnt_up = 1; act_cmp_up = 2'b10; act_cmp_dn = 2'b01; tick();
        cmp_hit = 0; #1; check("R5 compare up uses up action");

        // R6: every source
        for (int s = 0; s < 8; s++) begin
            src_sel = 3'(s); dead_main = 1; dead_comp = 1; sig_in = 1; cap_hit = 1;
            #1; check("R6 source select");
            sig_in = 0; cap_hit = 0; dead_comp = 0; #1; check("R6 source select alt");
        end
        src_sel = 0;

        // R7: independent forces
        for (int f = 0; f < 16; f++) begin
            frc_main = 2'(f); frc_comp = 2'(f >> 2); #1; check("R7 force pair");
        end
        frc_main = 0; frc_comp = 0;

        // R8: synchronous fault takes effect one cycle late
        flt_ovr_en = 1; safe_main = 1; safe_comp = 1; set_wave(0);
        fault_lvl = 1; #1; check("R8 fault not yet captured");
        tick(); fault_lvl = 0; #1; check("R8 captured fault forces safe");
        tick(); #1; check("R8 fault released");
        flt_ovr_en = 0; dbg_ovr_en = 1; dbg_halt = 1; tick(); dbg_halt = 0;
        #1; check("R8 debug halt forces safe");
        tick(); dbg_ovr_en = 0;

        // R9: asynchronous fault same cycle
        flt_ovr_en = 1; safe_main = 1; safe_comp = 0; fault_async = 1;
        #1; check("R9 async fault immediate");
        fault_async = 0; flt_ovr_en = 0; #1; check("R9 async fault cleared");

        // R10 / R11
        inv_en = 1; #1; check("R10 inversion");
        set_wave(1); #1; check("R10 inversion high wave");
        out_dis = 1; cnt_en = 0; idle_lvl = 1; #1; check("R11 disable beats idle");
        cnt_en = 1; frc_main = 2'b10; #1; check("R11 disable beats force");
        tick(); quiet();

        for (int i = 0; i < 4000; i++) rnd_step();

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule